// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial-side controller of a small byte-wide nonvolatile memory of 1024 locations. It runs on a fast system clock and acts as a mode-0 SPI slave. The serial clock, chip select, data input and hold input are brought into that clock domain and edge-detected. Input bits are taken on serial clock rising edges. The serial output changes on falling edges. All fields travel most significant bit first.

After chip select falls, the block collects an 8-bit command. Depending on the command, it then collects a 16-bit address and data bytes, or it streams bytes back. It does not contain the storage, the write timer or the protection logic. Instead it issues requests to three neighbours:
- an array read port: `rd_req_o` and `rd_addr_o`, with `rd_data_i` returned in the same cycle;
- a page-write buffer: `pg_push_o` and `pg_commit_o`;
- a status and protection unit: `wen_set_o`, `wen_clr_o`, `sr_wr_o`, with `status_i` and `wip_i` coming back.

The serial output is modelled as a data bit plus an output enable. The enable is low whenever the line would be high impedance.

Top module: `spi_mem_front`

## Requirements
- R1: Command bytes have the form 0000_xabc, and bit 3 (x) is ignored. abc=110 gives one `wen_set_o` pulse and abc=100 gives one `wen_clr_o` pulse. Both pulses occur once the eighth command bit is taken.
- R2: Command abc=011 reads the array. Sixteen address bits follow. Only the low 10 bits are kept and the upper six are ignored. Data bytes are then shifted out MSB first with `so_oe_o` high. Each byte is fetched through a one-cycle `rd_req_o` strobe, and `rd_data_i` is used in that same cycle.
- R3: During a read, the address advances by one after every byte. It wraps from 1023 to 0.
- R4: Once the read address is complete, SI has no effect on the bytes returned.
- R5: Command abc=010 writes the array. After the 16-bit address, each complete data byte gives one `pg_push_o` pulse carrying that byte on `wdata_o` and its target on `pg_addr_o`. The low 5 bits of the target then advance modulo 32, and the upper bits stay fixed.
- R6: When chip select rises after an array write, `pg_commit_o` pulses once. This happens only if at least one byte was pushed and the rise falls on a byte boundary. Otherwise no commit is issued.
- R7: Command abc=001 takes one data byte and gives one `sr_wr_o` pulse carrying it on `wdata_o`. Later bits in the same selection are ignored.
- R8: Command abc=101 shifts `status_i` out MSB first. A fresh copy of `status_i` is loaded for every byte, for as long as the clock runs.
- R9: A command byte with any of bits 7..4 set, or with abc of 000 or 111, produces no pulse. It also keeps `so_oe_o` low until chip select falls again.
- R10: While chip select is high, `so_oe_o` is low and serial clock or SI activity produces no pulse.
- R11: Hold taken low while the serial clock is low suspends the transfer and forces `so_oe_o` low. Serial clock edges during hold are ignored. Releasing hold while the serial clock is low resumes at the same bit.
- R12: While `wip_i` is high when a command completes, every command except status read (abc=101) is treated as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Transfer pause, active low |
| wip_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| status_i | input | 8 | Status byte to return on status read |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Serial output enable |
| rd_req_o | output | 1 | Array fetch strobe |
| rd_addr_o | output | 10 | Array read address |
| wen_set_o | output | 1 | Set write-enable latch |
| wen_clr_o | output | 1 | Clear write-enable latch |
| sr_wr_o | output | 1 | Status write strobe |
| pg_push_o | output | 1 | Page-buffer byte strobe |
| pg_addr_o | output | 10 | Target of pushed byte |
| wdata_o | output | 8 | Byte for page buffer or status write |
| pg_commit_o | output | 1 | Start programming the page |

## Verification
Hold is the hardest case to reach. It must begin and end while the serial clock is low and in the middle of an output byte, and serial clock pulses must arrive while it is held. The master task therefore accepts a bit index at which it drops hold. It then checks that the output enable is low, issues stray clock pulses with a changed SI, releases hold and finishes the byte, and the byte must still match the array model. A chip-select rise partway through a write byte is also reached directly, using a task that shifts only part of a byte. Read wraparound is reached by starting a read at address 1022.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OP,
        PH_ADDR,
        PH_RD,
        PH_WR,
        PH_SRIN,
        PH_SROUT,
        PH_MUTE
    } phase_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WEN_SET,
        CMD_WEN_CLR,
        CMD_SR_RD,
        CMD_SR_WR,
        CMD_RD,
        CMD_WR
    } cmd_e;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[i] <= RST_VAL;
            end else begin
                stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_opdec.sv
module spi_fe_opdec
    import spi_fe_pkg::*;
(
    input  logic [7:0] op,
    input  logic       wip,
    output cmd_e       cmd
);
    cmd_e raw;

    always_comb begin
        raw = CMD_NONE;
        if (op[7:4] == 4'b0000) begin
            unique case (op[2:0])
                3'b110:  raw = CMD_WEN_SET;
                3'b100:  raw = CMD_WEN_CLR;
                3'b101:  raw = CMD_SR_RD;
                3'b001:  raw = CMD_SR_WR;
                3'b011:  raw = CMD_RD;
                3'b010:  raw = CMD_WR;
                default: raw = CMD_NONE;
            endcase
        end
        // Busy array: only the status query gets through.
        cmd = (wip && raw != CMD_SR_RD) ? CMD_NONE : raw;
    end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_fe_pkg::*;
#(
    parameter int AW          = 10,
    parameter int XFER_AW     = 16,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          csn_i,
    input  logic          si_i,
    input  logic          hold_n_i,
    input  logic          wip_i,
    input  logic [7:0]    rd_data_i,
    input  logic [7:0]    status_i,
    output logic          so_o,
    output logic          so_oe_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          wen_set_o,
    output logic          wen_clr_o,
    output logic          sr_wr_o,
    output logic          pg_push_o,
    output logic [AW-1:0] pg_addr_o,
    output logic [7:0]    wdata_o,
    output logic          pg_commit_o
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(XFER_AW) + 1;
    localparam logic [CW-1:0] CNT_ADDR_END = CW'(XFER_AW - 1);
    localparam logic [CW-1:0] CNT_BYTE_END = CW'(7);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [7:0]    sh;
        logic [AW-1:0] addr;
        logic [7:0]    tx;
        logic          out_vld;
        logic          hold;
        logic          wrote;
        logic          is_rd;
        logic          sck_prev;
        logic          wen_set;
        logic          wen_clr;
        logic          sr_wr;
        logic          pg_push;
        logic          pg_commit;
        logic [AW-1:0] pg_addr;
        logic [7:0]    wdata;
    } fe_state_t;

    localparam fe_state_t FE_RESET = '{phase: PH_IDLE, default: '0};

    fe_state_t q, d;
    logic      sck_s, csn_s, si_s, hold_n_s;
    logic      sck_rise, sck_fall, out_phase;
    logic [7:0] sh_next;
    cmd_e      cmd;

    spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, csn_i, si_i, hold_n_i}),
        .q     ({sck_s, csn_s, si_s, hold_n_s})
    );

    assign sh_next = {q.sh[6:0], si_s};

    spi_fe_opdec u_dec (
        .op  (sh_next),
        .wip (wip_i),
        .cmd (cmd)
    );

    assign sck_rise  = sck_s & ~q.sck_prev & ~q.hold;
    assign sck_fall  = ~sck_s & q.sck_prev & ~q.hold;
    assign out_phase = (q.phase == PH_RD) || (q.phase == PH_SROUT);

    always_comb begin
        d           = q;
        d.sck_prev  = sck_s;
        d.wen_set   = 1'b0;
        d.wen_clr   = 1'b0;
        d.sr_wr     = 1'b0;
        d.pg_push   = 1'b0;
        d.pg_commit = 1'b0;

        if (csn_s) begin
            d.pg_commit = (q.phase == PH_WR) && q.wrote && (q.cnt == '0);
            d.phase     = PH_IDLE;
            d.hold      = 1'b0;
            d.out_vld   = 1'b0;
            d.wrote     = 1'b0;
        end else if (q.phase == PH_IDLE) begin
            d.phase = PH_OP;
            d.cnt   = '0;
        end else begin
            if (!sck_s) begin
                d.hold = ~hold_n_s;
            end
            if (sck_rise) begin
                unique case (q.phase)
                    PH_OP: begin
                        d.sh  = sh_next;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_BYTE_END) begin
                            d.cnt = '0;
                            unique case (cmd)
                                CMD_WEN_SET: begin d.wen_set = 1'b1; d.phase = PH_MUTE; end
                                CMD_WEN_CLR: begin d.wen_clr = 1'b1; d.phase = PH_MUTE; end
                                CMD_SR_RD:   d.phase = PH_SROUT;
                                CMD_SR_WR:   d.phase = PH_SRIN;
                                CMD_RD:      begin d.phase = PH_ADDR; d.is_rd = 1'b1; end
                                CMD_WR:      begin d.phase = PH_ADDR; d.is_rd = 1'b0; end
                                default:     d.phase = PH_MUTE;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        d.addr = {q.addr[AW-2:0], si_s};
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == CNT_ADDR_END) begin
                            d.cnt   = '0;
                            d.phase = q.is_rd ? PH_RD : PH_WR;
                        end
                    end
                    PH_WR, PH_SRIN: begin
                        d.sh  = sh_next;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_BYTE_END) begin
                            d.cnt   = '0;
                            d.wdata = sh_next;
                            if (q.phase == PH_SRIN) begin
                                d.sr_wr = 1'b1;
                                d.phase = PH_MUTE;
                            end else begin
                                d.pg_push = 1'b1;
                                d.pg_addr = q.addr;
                                d.wrote   = 1'b1;
                                d.addr    = {q.addr[AW-1:PW], q.addr[PW-1:0] + 1'b1};
                            end
                        end
                    end
                    PH_RD, PH_SROUT: begin
                        d.cnt = (q.cnt == CNT_BYTE_END) ? '0 : q.cnt + 1'b1;
                        if (q.phase == PH_RD && q.cnt == CNT_BYTE_END) begin
                            d.addr = q.addr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (sck_fall && out_phase) begin
                if (q.cnt == '0) begin
                    d.tx      = (q.phase == PH_RD) ? rd_data_i : status_i;
                    d.out_vld = 1'b1;
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= FE_RESET;
        end else begin
            q <= d;
        end
    end

    assign rd_req_o    = sck_fall && !csn_s && (q.phase == PH_RD) && (q.cnt == '0);
    assign rd_addr_o   = q.addr;
    assign so_o        = q.tx[7];
    assign so_oe_o     = q.out_vld && !q.hold && out_phase;
    assign wen_set_o   = q.wen_set;
    assign wen_clr_o   = q.wen_clr;
    assign sr_wr_o     = q.sr_wr;
    assign pg_push_o   = q.pg_push;
    assign pg_addr_o   = q.pg_addr;
    assign wdata_o     = q.wdata;
    assign pg_commit_o = q.pg_commit;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csn_i,
    input logic       csn_s,
    input logic       wip_i,
    input logic       so_oe_o,
    input logic       hold_q,
    input logic [7:0] tx_q,
    input logic [4:0] cnt_q,
    input logic       rd_req_o,
    input logic       wen_set_o,
    input logic       wen_clr_o,
    input logic       sr_wr_o,
    input logic       pg_push_o,
    input logic       pg_commit_o
);
    // R10: deselected for several cycles means the output is released
    p_oe_off_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !so_oe_o);

    // R1: request strobes to neighbours never coincide
    p_strobe_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_o, wen_set_o, wen_clr_o, sr_wr_o, pg_push_o, pg_commit_o}));

    // R11: while held, output shifter and bit position are frozen
    p_hold_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && $past(hold_q)) |-> ($stable(tx_q) && $stable(cnt_q)));

    // R12: a latch-set request never follows a busy cycle
    p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_set_o || wen_clr_o) |-> !$past(wip_i));

    // R6: commit only issued after chip select was seen high
    p_commit_on_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_commit_o |-> $past(csn_s));
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csn_i       (csn_i),
    .csn_s       (csn_s),
    .wip_i       (wip_i),
    .so_oe_o     (so_oe_o),
    .hold_q      (q.hold),
    .tx_q        (q.tx),
    .cnt_q       (5'(q.cnt)),
    .rd_req_o    (rd_req_o),
    .wen_set_o   (wen_set_o),
    .wen_clr_o   (wen_clr_o),
    .sr_wr_o     (sr_wr_o),
    .pg_push_o   (pg_push_o),
    .pg_commit_o (pg_commit_o)
);

// File: tb/spi_mem_front_tb.sv
module spi_mem_front_tb;
    localparam int AW   = 10;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
    logic [7:0] status = 8'h00;
    logic [7:0] rd_data;
    logic so, so_oe, rd_req, wen_set, wen_clr, sr_wr, pg_push, pg_commit;
    logic [AW-1:0] rd_addr, pg_addr;
    logic [7:0] wdata;

    logic [7:0] mem [1024];
    int checks = 0, failures = 0, pulses = 0;
    bit done = 0;

    typedef struct { int kind; int addr; int data; } ev_t;
    ev_t exp_q [$];

    always #4 clk = ~clk;

    assign rd_data = mem[rd_addr];

    spi_mem_front u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si),
        .hold_n_i(hold_n), .wip_i(wip), .rd_data_i(rd_data), .status_i(status),
        .so_o(so), .so_oe_o(so_oe), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .wen_set_o(wen_set), .wen_clr_o(wen_clr), .sr_wr_o(sr_wr),
        .pg_push_o(pg_push), .pg_addr_o(pg_addr), .wdata_o(wdata),
        .pg_commit_o(pg_commit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic expect_ev(input int kind, input int addr, input int data);
        ev_t e;
        e.kind = kind; e.addr = addr; e.data = data;
        exp_q.push_back(e);
    endtask

    // Monitor: kinds 1 set, 2 clear, 3 status write, 4 push, 5 commit
    always @(negedge clk) begin
        int kind;
        kind = 0;
        if (wen_set)   kind = 1;
        if (wen_clr)   kind = 2;
        if (sr_wr)     kind = 3;
        if (pg_push)   kind = 4;
        if (pg_commit) kind = 5;
        if (kind != 0) begin
            pulses++;
            if (exp_q.size() == 0) begin
                chk(0, "R1/R9/R10/R12 unexpected strobe", kind, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk(e.kind == kind, "R1/R5/R6/R7 strobe kind", kind, e.kind);
                if (kind == 3) chk(int'(wdata) == e.data, "R7 status data", wdata, e.data);
                if (kind == 4) begin
                    chk(int'(pg_addr) == e.addr, "R5 push address", pg_addr, e.addr);
                    chk(int'(wdata) == e.data, "R5 push data", wdata, e.data);
                end
            end
        end
    end

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_low();
        csn = 1'b0;
        half_wait(); half_wait();
    endtask

    task automatic cs_high();
        half_wait();
        csn = 1'b1;
        repeat (4) half_wait();
    endtask

    task automatic send_byte(input logic [7:0] tx, output logic [7:0] rx,
                             output bit oe_all, input int hold_at);
        oe_all = 1;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) begin
                hold_n = 1'b0;
                half_wait(); half_wait();
                chk(so_oe == 1'b0, "R11 output released in hold", so_oe, 0);
                si = ~si;
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; half_wait(); sck = 1'b0; half_wait();
                end
                hold_n = 1'b1;
                half_wait();
            end
            si = tx[i];
            half_wait();
            rx[i] = so;
            if (!so_oe) oe_all = 0;
            sck = 1'b1;
            half_wait();
            sck = 1'b0;
        end
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            half_wait();
            sck = 1'b1;
            half_wait();
            sck = 1'b0;
        end
    endtask

    task automatic do_read(input logic [15:0] a, input int nbytes, input int hold_byte,
                           input string req);
        logic [7:0] rx;
        bit oe;
        int ea;
        cs_low();
        send_byte(8'h03, rx, oe, -1);
        send_byte(a[15:8], rx, oe, -1);
        send_byte(a[7:0], rx, oe, -1);
        ea = int'(a[9:0]);
        for (int b = 0; b < nbytes; b++) begin
            send_byte(8'hA5 ^ 8'(b), rx, oe, (b == hold_byte) ? 3 : -1);
            chk(rx == mem[ea], req, rx, mem[ea]);
            chk(oe, "R2 output enabled while reading", oe, 1);
            ea = (ea + 1) % 1024;
        end
        cs_high();
    endtask

    initial begin
        logic [7:0] rx;
        bit oe;
        int p0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(so_oe == 1'b0, "R10 reset output disabled", so_oe, 0);
        chk(pulses == 0, "R10 no strobe after reset", pulses, 0);

        // R1: latch set with and without bit 3, latch clear
        expect_ev(1, 0, 0);
        cs_low(); send_byte(8'h06, rx, oe, -1); cs_high();
        expect_ev(1, 0, 0);
        cs_low(); send_byte(8'h0E, rx, oe, -1); cs_high();
        expect_ev(2, 0, 0);
        cs_low(); send_byte(8'h04, rx, oe, -1); cs_high();
        chk(exp_q.size() == 0, "R1 latch strobes consumed", exp_q.size(), 0);

        // R2/R4: upper address bits ignored, SI toggling during data
        do_read(16'hFC05, 3, -1, "R2 R4 read data");
        // R3: wrap from top of array
        do_read(16'h03FE, 4, -1, "R3 read wraparound");
        // R11: hold in the middle of the second byte
        do_read(16'h0123, 3, 1, "R11 read across hold");

        // R8: status stream reloads every byte
        status = 8'hA6;
        cs_low(); send_byte(8'h05, rx, oe, -1);
        send_byte(8'h00, rx, oe, -1);
        chk(rx == 8'hA6 && oe, "R8 status byte 1", rx, 8'hA6);
        status = 8'h3C;
        send_byte(8'h00, rx, oe, -1);
        send_byte(8'h00, rx, oe, -1);
        chk(rx == 8'h3C && oe, "R8 status byte reloaded", rx, 8'h3C);
        cs_high();

        // R7: status write via opcode with bit 3 set; extra byte ignored
        expect_ev(3, 0, 8'h8C);
        cs_low(); send_byte(8'h09, rx, oe, -1); send_byte(8'h8C, rx, oe, -1);
        send_byte(8'h06, rx, oe, -1); cs_high();
        chk(exp_q.size() == 0, "R7 single status strobe", exp_q.size(), 0);

        // R5/R6: page write wrapping inside the page
        expect_ev(4, 10'h3FE, 8'h11);
        expect_ev(4, 10'h3FF, 8'h22);
        expect_ev(4, 10'h3E0, 8'h33);
        expect_ev(4, 10'h3E1, 8'h44);
        expect_ev(5, 0, 0);
        cs_low(); send_byte(8'h02, rx, oe, -1);
        send_byte(8'hC3, rx, oe, -1); send_byte(8'hFE, rx, oe, -1);
        send_byte(8'h11, rx, oe, -1); send_byte(8'h22, rx, oe, -1);
        send_byte(8'h33, rx, oe, -1); send_byte(8'h44, rx, oe, -1);
        chk(so_oe == 1'b0, "R5 output idle during write", so_oe, 0);
        cs_high();
        chk(exp_q.size() == 0, "R5 R6 write events consumed", exp_q.size(), 0);

        // R6: partial trailing byte aborts the commit
        expect_ev(4, 10'h040, 8'h5A);
        cs_low(); send_byte(8'h0A, rx, oe, -1);
        send_byte(8'h00, rx, oe, -1); send_byte(8'h40, rx, oe, -1);
        send_byte(8'h5A, rx, oe, -1); send_bits(8'hFF, 3);
        cs_high();
        chk(exp_q.size() == 0, "R6 no commit on partial byte", exp_q.size(), 0);

        // R6: no data bytes, no commit
        p0 = pulses;
        cs_low(); send_byte(8'h02, rx, oe, -1);
        send_byte(8'h00, rx, oe, -1); send_byte(8'h10, rx, oe, -1);
        cs_high();
        chk(pulses == p0, "R6 no commit without data", pulses - p0, 0);

        // R9: invalid opcodes silence the interface
        p0 = pulses;
        cs_low(); send_byte(8'h47, rx, oe, -1);
        send_byte(8'h06, rx, oe, -1); send_byte(8'h05, rx, oe, -1);
        chk(!oe, "R9 output stays off after bad opcode", oe, 0);
        cs_high();
        cs_low(); send_byte(8'h07, rx, oe, -1); send_byte(8'h06, rx, oe, -1);
        chk(!oe, "R9 output off after code 111", oe, 0);
        cs_high();
        chk(pulses == p0, "R9 no strobe after bad opcode", pulses - p0, 0);

        // R10: activity while deselected
        p0 = pulses;
        send_byte(8'h06, rx, oe, -1); send_byte(8'h03, rx, oe, -1);
        chk(!oe, "R10 output off while deselected", oe, 0);
        repeat (2) half_wait();
        chk(pulses == p0, "R10 no strobe while deselected", pulses - p0, 0);

        // R12: busy array blocks all but status read
        wip = 1'b1;
        p0 = pulses;
        cs_low(); send_byte(8'h06, rx, oe, -1); cs_high();
        cs_low(); send_byte(8'h03, rx, oe, -1); send_byte(8'h00, rx, oe, -1);
        send_byte(8'h05, rx, oe, -1); send_byte(8'h00, rx, oe, -1);
        chk(!oe, "R12 read blocked while busy", oe, 0);
        cs_high();
        chk(pulses == p0, "R12 no strobe while busy", pulses - p0, 0);
        status = 8'hFF;
        cs_low(); send_byte(8'h05, rx, oe, -1); send_byte(8'h00, rx, oe, -1);
        chk(rx == 8'hFF && oe, "R12 status read while busy", rx, 8'hFF);
        cs_high();
        wip = 1'b0;

        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule